// File: doc/BRIEF.md
# Sector Erase Batching Window

This block gathers sector erase requests into one batch before an embedded erase begins. The first sector erase command opens an acceptance window. Each accepted command sets its sector's bit in a selection bitmap and restarts the full window. When the window runs out with no new sector command, the block raises the DQ3 status bit and pulses an erase-start strobe toward the erase engine. From then until the engine reports completion, only the erase suspend command has any effect.

A chip erase command does not use the window. When the block is idle, it selects every sector and starts the erase on the next edge. Command decoding is done upstream: one valid strobe with a two-bit command kind and a sector index is presented for each command. The erase engine closes the operation with a one-cycle done pulse. That pulse clears the bitmap and returns DQ3 to 0.

Top module: `erase_batch_window`

## Requirements
- R1: After reset, `dq3_status`, `erase_start`, `suspend_out` and every bit of `sector_map` are 0.
- R2: When idle, a command of kind 1 (sector erase) with index i below NUM_SECT opens the window and sets `sector_map` bit i at the sampling edge, while `dq3_status` stays 0.
- R3: If no further sector command arrives, `dq3_status` becomes 1 exactly WIN_CYC clock edges after the edge that accepted the last sector command.
- R4: A sector command accepted inside the window ORs its bit into `sector_map` and restarts the full WIN_CYC period from its own sampling edge.
- R5: `erase_start` is high for exactly one cycle, and only in the cycle in which `dq3_status` first becomes 1.
- R6: A sector command sampled on the edge at which the window expires is dropped: its bit is not set, and the erase starts on that edge.
- R7: While `dq3_status` is 1, commands of kind 0 (other), 1 (sector) and 2 (chip erase) change neither `sector_map` nor `dq3_status`.
- R8: A command of kind 3 (erase suspend) sampled while `dq3_status` is 1 gives a one-cycle `suspend_out` pulse at that edge. A suspend command sampled at any other time gives no pulse.
- R9: When idle, a command of kind 2 (chip erase) sets every bit of `sector_map`, and sets `dq3_status` and `erase_start`, at its sampling edge, without waiting for a window.
- R10: An `engine_done` pulse sampled while `dq3_status` is 1 clears `sector_map` and `dq3_status` at that edge, after which a new sector command opens a new window.
- R11: Inside the window, commands of kind 0, 2 and 3 are ignored: the bitmap keeps its value and the window expires at the time set by the last sector command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_kind | input | 2 | 0 other, 1 sector erase, 2 chip erase, 3 erase suspend |
| cmd_sector | input | IDX_W | Sector index for a sector erase command |
| engine_done | input | 1 | One-cycle pulse from the erase engine at completion |
| sector_map | output | NUM_SECT | Bitmap of sectors selected for the batch |
| erase_start | output | 1 | One-cycle pulse that starts the erase engine |
| dq3_status | output | 1 | 0 while the window is open or idle, 1 during the erase |
| suspend_out | output | 1 | One-cycle forwarded erase suspend request |

## Verification
Every result is registered once. A command presented in a cycle shows in `sector_map`, `erase_start`, `suspend_out` and `dq3_status` just after the edge that samples it. The window expiry is due WIN_CYC edges after the last accepting edge. The bench drives inputs on falling edges and counts rising edges from the sampling edge. It checks `dq3_status` on the falling edge after edge WIN_CYC-1, where it must still be 0, and on the falling edge after edge WIN_CYC, where it must be 1. The dropped-command case is placed on exactly that expiry edge.

// File: rtl/erase_batch_pkg.sv
package erase_batch_pkg;

    typedef enum logic [1:0] {
        CMD_OTHER   = 2'd0,
        CMD_SECTOR  = 2'd1,
        CMD_CHIP    = 2'd2,
        CMD_SUSPEND = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_WINDOW = 2'd1,
        PH_ERASE  = 2'd2
    } phase_e;

endpackage

// File: rtl/ebw_window_timer.sv
module ebw_window_timer #(
    parameter int WIN_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic last
);
    localparam int CNT_W = $clog2(WIN_CYC + 1) + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (restart) begin
            tmr_d.cnt = CNT_W'(WIN_CYC - 1);
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign last = (tmr_q.cnt == '0);
endmodule

// File: rtl/ebw_sector_map.sv
module ebw_sector_map #(
    parameter int NUM_SECT = 16,
    parameter int IDX_W    = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                fill_all,
    input  logic                clear,
    output logic [NUM_SECT-1:0] map
);
    typedef struct packed {
        logic [NUM_SECT-1:0] bits;
    } map_t;

    map_t map_d, map_q;

    always_comb begin
        map_d = map_q;
        if (clear) begin
            map_d.bits = '0;
        end else if (fill_all) begin
            map_d.bits = '1;
        end else begin
            for (int i = 0; i < NUM_SECT; i++) begin
                if (set_en && (set_idx == IDX_W'(i))) map_d.bits[i] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) map_q <= '0;
        else        map_q <= map_d;
    end

    assign map = map_q.bits;
endmodule

// File: rtl/ebw_phase_ctrl.sv
module ebw_phase_ctrl
    import erase_batch_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_valid,
    input  cmd_kind_e cmd_kind,
    input  logic      idx_ok,
    input  logic      win_last,
    input  logic      engine_done,
    output logic      timer_restart,
    output logic      map_set,
    output logic      map_fill,
    output logic      map_clear,
    output phase_e    phase,
    output logic      erase_start,
    output logic      suspend_out
);
    typedef struct packed {
        phase_e phase;
        logic   start;
        logic   susp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic sect_cmd;

    assign sect_cmd = cmd_valid && (cmd_kind == CMD_SECTOR) && idx_ok;

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.start   = 1'b0;
        ctl_d.susp    = 1'b0;
        timer_restart = 1'b0;
        map_set       = 1'b0;
        map_fill      = 1'b0;
        map_clear     = 1'b0;
        unique case (ctl_q.phase)
            PH_IDLE: begin
                if (sect_cmd) begin
                    timer_restart = 1'b1;
                    map_set       = 1'b1;
                    ctl_d.phase   = PH_WINDOW;
                end else if (cmd_valid && (cmd_kind == CMD_CHIP)) begin
                    map_fill    = 1'b1;
                    ctl_d.phase = PH_ERASE;
                    ctl_d.start = 1'b1;
                end
            end
            PH_WINDOW: begin
                if (win_last) begin
                    ctl_d.phase = PH_ERASE;
                    ctl_d.start = 1'b1;
                end else if (sect_cmd) begin
                    timer_restart = 1'b1;
                    map_set       = 1'b1;
                end
            end
            PH_ERASE: begin
                if (cmd_valid && (cmd_kind == CMD_SUSPEND)) ctl_d.susp = 1'b1;
                if (engine_done) begin
                    map_clear   = 1'b1;
                    ctl_d.phase = PH_IDLE;
                end
            end
            default: ctl_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.phase <= PH_IDLE;
            ctl_q.start <= 1'b0;
            ctl_q.susp  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign phase       = ctl_q.phase;
    assign erase_start = ctl_q.start;
    assign suspend_out = ctl_q.susp;
endmodule

// File: rtl/erase_batch_window.sv
module erase_batch_window
    import erase_batch_pkg::*;
#(
    parameter int NUM_SECT = 16,
    parameter int WIN_CYC  = 8,
    parameter int IDX_W    = (NUM_SECT > 1) ? $clog2(NUM_SECT) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_kind,
    input  logic [IDX_W-1:0]    cmd_sector,
    input  logic                engine_done,
    output logic [NUM_SECT-1:0] sector_map,
    output logic                erase_start,
    output logic                dq3_status,
    output logic                suspend_out
);
    logic   idx_ok;
    logic   win_last;
    logic   timer_restart;
    logic   map_set;
    logic   map_fill;
    logic   map_clear;
    phase_e phase;

    assign idx_ok = (32'(cmd_sector) < NUM_SECT);

    ebw_window_timer #(
        .WIN_CYC (WIN_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .last    (win_last)
    );

    ebw_sector_map #(
        .NUM_SECT (NUM_SECT),
        .IDX_W    (IDX_W)
    ) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_en   (map_set),
        .set_idx  (cmd_sector),
        .fill_all (map_fill),
        .clear    (map_clear),
        .map      (sector_map)
    );

    ebw_phase_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_kind      (cmd_kind_e'(cmd_kind)),
        .idx_ok        (idx_ok),
        .win_last      (win_last),
        .engine_done   (engine_done),
        .timer_restart (timer_restart),
        .map_set       (map_set),
        .map_fill      (map_fill),
        .map_clear     (map_clear),
        .phase         (phase),
        .erase_start   (erase_start),
        .suspend_out   (suspend_out)
    );

    assign dq3_status = (phase == PH_ERASE);
endmodule

// File: rtl/erase_batch_window_chk.sv
module erase_batch_window_chk #(
    parameter int NUM_SECT = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cmd_valid,
    input logic [1:0]          cmd_kind,
    input logic                engine_done,
    input logic [NUM_SECT-1:0] sector_map,
    input logic                erase_start,
    input logic                dq3_status,
    input logic                suspend_out
);
    // R5
    start_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq3_status) |-> erase_start);

    // R5
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |=> !erase_start);

    // R5
    start_needs_dq3_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> dq3_status);

    // R7
    erase_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq3_status && cmd_valid && (cmd_kind != 2'd3) && !engine_done)
            |=> ($stable(sector_map) && dq3_status));

    // R8
    suspend_only_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_out |-> $past(dq3_status));

    // R10
    done_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dq3_status && engine_done) |=> (!dq3_status && (sector_map == '0)));
endmodule

bind erase_batch_window erase_batch_window_chk #(.NUM_SECT(NUM_SECT)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_kind    (cmd_kind),
    .engine_done (engine_done),
    .sector_map  (sector_map),
    .erase_start (erase_start),
    .dq3_status  (dq3_status),
    .suspend_out (suspend_out)
);

// File: tb/erase_batch_window_bench.sv
`timescale 1ns/1ps
module erase_batch_window_bench;
    localparam int NS = 16;
    localparam int W  = 8;
    localparam int IW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_kind = 2'd0;
    logic [IW-1:0] cmd_sector = '0;
    logic          engine_done = 1'b0;
    logic [NS-1:0] sector_map;
    logic          erase_start;
    logic          dq3_status;
    logic          suspend_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    erase_batch_window #(.NUM_SECT(NS), .WIN_CYC(W)) u_erase_batch_window (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_sector(cmd_sector), .engine_done(engine_done), .sector_map(sector_map),
        .erase_start(erase_start), .dq3_status(dq3_status), .suspend_out(suspend_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // present a command for one cycle; returns on the falling edge after its sampling edge
    task automatic issue(input logic [1:0] k, input int idx);
        cmd_valid  = 1'b1;
        cmd_kind   = k;
        cmd_sector = IW'(idx);
        @(negedge clk);
        cmd_valid  = 1'b0;
        cmd_kind   = 2'd0;
    endtask

    task automatic finish_erase();
        engine_done = 1'b1;
        @(negedge clk);
        engine_done = 1'b0;
        check("R10 dq3 cleared", 32'(dq3_status), 0);
        check("R10 map cleared", 32'(sector_map), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 dq3", 32'(dq3_status), 0);
        check("R1 map", 32'(sector_map), 0);
        check("R1 start", 32'(erase_start), 0);
        check("R1 suspend", 32'(suspend_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_single();
        issue(2'd1, 6);
        check("R2 bit set", 32'(sector_map), 32'h0040);
        check("R2 dq3 low", 32'(dq3_status), 0);
        repeat (W - 1) @(negedge clk);
        check("R3 dq3 still low", 32'(dq3_status), 0);
        check("R5 no early start", 32'(erase_start), 0);
        @(negedge clk);
        check("R3 dq3 high", 32'(dq3_status), 1);
        check("R5 start pulse", 32'(erase_start), 1);
        @(negedge clk);
        check("R5 start drops", 32'(erase_start), 0);
        finish_erase();
    endtask

    task automatic t_restart();
        issue(2'd1, 3);
        repeat (3) @(negedge clk);
        issue(2'd1, 12);
        check("R4 bits ORed", 32'(sector_map), 32'h1008);
        repeat (W - 1) @(negedge clk);
        check("R4 window restarted", 32'(dq3_status), 0);
        @(negedge clk);
        check("R4 expiry after restart", 32'(dq3_status), 1);
        finish_erase();
    endtask

    task automatic t_late_drop();
        issue(2'd1, 1);
        repeat (W - 1) @(negedge clk);
        issue(2'd1, 9);
        check("R6 dq3 high", 32'(dq3_status), 1);
        check("R6 late bit dropped", 32'(sector_map), 32'h0002);
        check("R6 start", 32'(erase_start), 1);
        finish_erase();
    endtask

    task automatic t_erase_ignore_and_suspend();
        issue(2'd1, 0);
        repeat (W) @(negedge clk);
        check("R7 erasing", 32'(dq3_status), 1);
        issue(2'd1, 5);
        check("R7 sector ignored", 32'(sector_map), 32'h0001);
        issue(2'd2, 0);
        check("R7 chip ignored", 32'(sector_map), 32'h0001);
        issue(2'd0, 7);
        check("R7 other ignored dq3", 32'(dq3_status), 1);
        check("R8 no suspend yet", 32'(suspend_out), 0);
        issue(2'd3, 0);
        check("R8 suspend pulse", 32'(suspend_out), 1);
        check("R8 dq3 kept", 32'(dq3_status), 1);
        @(negedge clk);
        check("R8 suspend drops", 32'(suspend_out), 0);
        finish_erase();
        issue(2'd3, 0);
        check("R8 idle suspend ignored", 32'(suspend_out), 0);
    endtask

    task automatic t_chip();
        issue(2'd2, 0);
        check("R9 map full", 32'(sector_map), 32'h0000FFFF);
        check("R9 dq3 at once", 32'(dq3_status), 1);
        check("R9 start", 32'(erase_start), 1);
        finish_erase();
        issue(2'd1, 15);
        check("R10 new window opens", 32'(sector_map), 32'h8000);
        check("R10 dq3 low in window", 32'(dq3_status), 0);
        repeat (W) @(negedge clk);
        finish_erase();
    endtask

    task automatic t_window_other();
        issue(2'd1, 4);
        issue(2'd2, 0);
        issue(2'd3, 0);
        issue(2'd0, 2);
        check("R11 map kept", 32'(sector_map), 32'h0010);
        check("R11 no suspend", 32'(suspend_out), 0);
        repeat (W - 1 - 3) @(negedge clk);
        check("R11 dq3 low", 32'(dq3_status), 0);
        @(negedge clk);
        check("R11 expiry unchanged", 32'(dq3_status), 1);
        finish_erase();
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_single();
        t_restart();
        t_late_drop();
        t_erase_ignore_and_suspend();
        t_chip();
        t_window_other();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule